// File: doc/BRIEF.md
# Overlapping Serial Pattern Detector

This block watches a one-bit serial stream and flags every arrival of the bit sequence 0,1,1,1,0. A match may share its leading 0 with the closing 0 of the match before it, so a stream such as 0,1,1,1,0,1,1,1,0 yields two separate hits. Everything runs on a single fast system clock. An internal prescaler emits a one-cycle sample enable every `DIV` system clocks. The serial input is taken, and the tracking state machine moves, only on that enable.

Each hit raises an output flag that stays up for `HOLD` sample periods (two by default), so a slow observer can see it. An 8-bit probe bus exposes the internal reset, the sample enable, the flag and a one-hot view of the tracker's five states. The external reset is active-low and asynchronous. It is released through a two-stage synchronizer.

Top module: `pat_watch`

## Requirements
- R1: While the internal reset is active, the probe shows bit 0 = 1, bit 1 = 0 and bits 7:3 = 5'b00001 (idle state), and `hit_o` is 0. Asserting `rst_n` clears the state and the flag at once, without waiting for a clock edge.
- R2: The sample enable, visible on probe bit 1, is high for exactly one system clock, and consecutive enables are `DIV` clocks apart.
- R3: `serial_i` is ignored except in the clock cycle where the enable is high. Between enables, the state bits and `hit_o` do not change.
- R4: When the enable takes a 0 while the tracker holds the prefix 0,1,1,1, `hit_o` goes high at that same clock edge.
- R5: Matches overlap. The closing 0 of a match counts as the leading 0 of the next one, so the tracker moves to the "one 0 seen" state (bits 7:3 = 5'b00010) rather than to idle.
- R6: After a hit, `hit_o` stays high for exactly two sample periods. It clears at the enable edge two enables after the match.
- R7: A sample that breaks a partial match moves the tracker to the longest prefix still matched. A 0 always leads to the "one 0 seen" state. A 1 taken after 0,1,1,1 returns it to idle.
- R8: The probe layout is: bit 0 internal reset active, bit 1 sample enable, bit 2 equal to `hit_o`, and bits 3..7 one-hot for the states idle, "0", "01", "011" and "0111", with exactly one of them set.
- R9: After `rst_n` rises, the internal reset stays active for two rising clock edges, so probe bit 0 reads 1 after the first edge and 0 after the second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| serial_i | input | 1 | Serial data bit, sampled on the internal enable |
| hit_o | output | 1 | Detection flag, held for two sample periods per match |
| probe_o | output | 8 | Debug bus: reset, enable, flag and one-hot state |

## Verification
The bench feeds back-to-back matches to confirm that the shared 0 is reused. A design that returned to idle after a hit would miss the second match. Streams of four 1s, 0,1,0 and 0,1,1,0 check the fallback target. Routing a stray 1 to the "0" state, or a stray 0 to idle, would show up there as a wrong one-hot state or as a lost later match. The bench toggles the input between enables to catch a tracker that samples on every clock. It measures the flag width in enable edges to catch an off-by-one hold counter, and it drops reset during a held flag to confirm the flag clears at once and that release takes two edges.

// File: rtl/pw_pkg.sv
package pw_pkg;
  localparam int unsigned PW_NUM_ST = 5;
  localparam int unsigned PW_PROBE_W = 8;

  // Tracker states: length of the matched prefix of 0,1,1,1,0
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_Z    = 3'd1,
    ST_ZO   = 3'd2,
    ST_ZOO  = 3'd3,
    ST_ZOOO = 3'd4
  } pw_st_e;
endpackage

// File: rtl/pw_rst_sync.sv
module pw_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/pw_tick.sv
module pw_tick #(
  parameter int unsigned DIV = 10000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (cnt_q == LAST) cnt_d = '0;
    else               cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/pw_track.sv
module pw_track
  import pw_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_i,
  input  logic                 bit_i,
  output logic                 match_o,
  output logic [PW_NUM_ST-1:0] st_oh_o
);
  pw_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: st_d = bit_i ? ST_IDLE : ST_Z;
      ST_Z:    st_d = bit_i ? ST_ZO   : ST_Z;
      ST_ZO:   st_d = bit_i ? ST_ZOO  : ST_Z;
      ST_ZOO:  st_d = bit_i ? ST_ZOOO : ST_Z;
      ST_ZOOO: st_d = bit_i ? ST_IDLE : ST_Z;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      st_q <= ST_IDLE;
    else if (tick_i) st_q <= st_d;
  end

  assign match_o = tick_i && (st_q == ST_ZOOO) && !bit_i;

  for (genvar gi = 0; gi < PW_NUM_ST; gi++) begin : g_oh
    assign st_oh_o[gi] = (st_q == pw_st_e'(gi));
  end
endmodule

// File: rtl/pw_hold.sv
module pw_hold #(
  parameter int unsigned HOLD = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic match_i,
  output logic flag_o
);
  localparam int unsigned CW = $clog2(HOLD + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (match_i)                    cnt_d = CW'(HOLD);
    else if (tick_i && cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign flag_o = (cnt_q != '0);
endmodule

// File: rtl/pat_watch.sv
module pat_watch
  import pw_pkg::*;
#(
  parameter int unsigned DIV  = 10000,
  parameter int unsigned HOLD = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  serial_i,
  output logic                  hit_o,
  output logic [PW_PROBE_W-1:0] probe_o
);
  logic                 rst_sync_n;
  logic                 tick;
  logic                 match;
  logic                 flag;
  logic [PW_NUM_ST-1:0] st_oh;

  pw_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pw_tick #(.DIV(DIV)) u_tick (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .tick_o (tick)
  );

  pw_track u_track (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .tick_i  (tick),
    .bit_i   (serial_i),
    .match_o (match),
    .st_oh_o (st_oh)
  );

  pw_hold #(.HOLD(HOLD)) u_hold (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .tick_i  (tick),
    .match_i (match),
    .flag_o  (flag)
  );

  assign hit_o   = flag;
  assign probe_o = {st_oh, flag, tick, ~rst_sync_n};
endmodule

// File: rtl/pw_chk.sv
module pw_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       din,
  input logic       hit,
  input logic [7:0] probe
);
  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |=> (probe[0] && probe[3] && !hit && !probe[1])); // R1

  AST_TICK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    probe[1] |=> !probe[1]); // R2

  AST_QUIET_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    !probe[1] |=> $stable(probe[7:2])); // R3

  AST_MATCH_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (probe[1] && probe[7] && !din) |=> (hit && probe[4])); // R4

  AST_BREAK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (probe[1] && probe[7] && din) |=> probe[3]); // R7

  AST_STATE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(probe[7:3]) == 1); // R8
endmodule

bind pat_watch pw_chk chk_i (
  .clk   (clk),
  .rst_n (rst_n),
  .din   (serial_i),
  .hit   (hit_o),
  .probe (probe_o)
);

// File: tb/pat_watch_tb_top.sv
module pat_watch_tb_top;
  localparam int unsigned DIV = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       din = 1'b1;
  logic       hit;
  logic [7:0] probe;

  int compared = 0;
  int mismatched = 0;

  always #10 clk = ~clk;

  pat_watch #(.DIV(DIV), .HOLD(2)) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .serial_i (din),
    .hit_o    (hit),
    .probe_o  (probe)
  );

  // {din, expected hit after sample, expected state one-hot idle..0111}
  localparam logic [6:0] VEC [0:25] = '{
    7'b1_0_00001, 7'b0_0_00010, 7'b1_0_00100, 7'b1_0_01000,
    7'b1_0_10000, 7'b0_1_00010, 7'b1_1_00100, 7'b1_0_01000,
    7'b1_0_10000, 7'b0_1_00010, 7'b1_1_00100, 7'b1_0_01000,
    7'b1_0_10000, 7'b1_0_00001, 7'b0_0_00010, 7'b1_0_00100,
    7'b0_0_00010, 7'b1_0_00100, 7'b1_0_01000, 7'b0_0_00010,
    7'b1_0_00100, 7'b1_0_01000, 7'b1_0_10000, 7'b0_1_00010,
    7'b0_1_00010, 7'b0_0_00010
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic b);
    @(negedge clk);
    din = b;
    while (!probe[1]) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 probe reset bit", 32'(probe[0]), 32'd1);
    chk("R1 enable low", 32'(probe[1]), 32'd0);
    chk("R1 idle state", 32'(probe[7:3]), 32'b00001);
    chk("R1 hit low", 32'(hit), 32'd0);

    // R9: release takes two edges
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 reset after one edge", 32'(probe[0]), 32'd1);
    @(negedge clk);
    chk("R9 reset after two edges", 32'(probe[0]), 32'd0);

    // R2: enable width and spacing
    while (!probe[1]) @(negedge clk);
    begin
      int n = 0;
      do begin
        @(negedge clk);
        n++;
        if (n == 1) chk("R2 enable one cycle", 32'(probe[1]), 32'd0);
      end while (!probe[1] && n < 100);
      chk("R2 enable spacing", 32'(n), 32'(DIV));
    end

    // R4 R5 R6 R7 R8: stimulus table
    for (int i = 0; i < 26; i++) begin
      step(VEC[i][6]);
      chk($sformatf("R4/R5/R6/R7 row %0d state", i), 32'(probe[7:3]), 32'(VEC[i][4:0]));
      chk($sformatf("R6 row %0d hit", i), 32'(hit), 32'(VEC[i][5]));
      chk($sformatf("R8 row %0d probe flag bit", i), 32'(probe[2]), 32'(VEC[i][5]));
    end

    // R3: toggles between enables are ignored (state is "0" here)
    step(1'b1);
    chk("R3 setup state 01", 32'(probe[7:3]), 32'b00100);
    din = 1'b0;
    @(negedge clk);
    chk("R3 state stable while input 0", 32'(probe[7:3]), 32'b00100);
    chk("R3 hit stable", 32'(hit), 32'd0);
    din = 1'b1;
    @(negedge clk);
    chk("R3 state stable after toggle", 32'(probe[7:3]), 32'b00100);
    step(1'b1);
    chk("R3 toggle not taken", 32'(probe[7:3]), 32'b01000);

    // R6: hit then R1 async clear mid-hold
    step(1'b1);
    step(1'b0);
    chk("R4 hit after match", 32'(hit), 32'd1);
    rst_n = 1'b0;
    #1;
    chk("R1 hit cleared by reset", 32'(hit), 32'd0);
    chk("R1 state idle by reset", 32'(probe[7:3]), 32'b00001);
    chk("R1 reset bit shown", 32'(probe[0]), 32'd1);
    din = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R9 reset released", 32'(probe[0]), 32'd0);
    step(1'b0);
    chk("R7 zero after reset goes to 0 state", 32'(probe[7:3]), 32'b00010);
    chk("R6 no stale hit after reset", 32'(hit), 32'd0);

    finish_run();
  end
endmodule